// File: doc/BRIEF.md
# Accumulator ALU with Nibble Flags

This block is the purely combinational eight-bit arithmetic and logic unit of an accumulator-based CPU. On each evaluation it takes the current accumulator, a second operand, the incoming flag byte and a four-bit operation code. It returns a result byte, a new flag byte and a write-enable that tells the surrounding datapath whether to store the result back into the accumulator. The surrounding datapath handles operand fetch, register selection and wide (16-bit) arithmetic. This block does none of them.

The block keeps all four condition flags in the upper nibble of the flag byte. Carry-in for the carrying operations is taken from that byte. A half-carry (carry or borrow out of bit 3) is produced so that a later decimal-adjust can correct a packed-BCD sum or difference. The direction of that correction is set by the subtract flag. The block has no registers, no clock and no handshake: the outputs follow the inputs within one combinational path, and the caller latches them on its own clock.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 decimal adjust, 9 complement, 10 set carry, 11 complement carry. `acc_we_o` is 1 for codes 0–6, 8 and 9, and 0 for codes 7, 10, 11 and 12–15.
- R2: Flag byte layout is Z in bit 7, N in bit 6, H in bit 5, C in bit 4. Bits 3:0 of `flags_o` are always 0, whatever `flags_i` holds.
- R3: Add (code 0) and add-with-carry (code 1) give result = (A + B + cin) mod 256, where cin is `flags_i` bit 4 for code 1 and 0 for code 0. C is set when the full sum is 0x100 or more. H is set on a carry out of bit 3 (bit 4 of result^A^B). N is 0 and Z is set when the result is 0.
- R4: Subtract (code 2) and subtract-with-borrow (code 3) give result = (A − B − cin) mod 256, where cin is `flags_i` bit 4 for code 3 and 0 for code 2. N is 1. C is set on a borrow from the full byte. H is set on a borrow from bit 4 (bit 4 of result^A^B). Z is set when the result is 0.
- R5: Compare (code 7) produces the flags of subtract (code 2) and drives `result_o` equal to A, with the write-enable low.
- R6: AND, XOR and OR set Z when the result is 0 and clear N, H and C.
- R7: Decimal adjust builds a correction from two terms. It includes 0x06 when H is set or A[3:0] > 9. It includes 0x60 when C is set, or A[7:4] > 9, or A[7:4] > 8 together with A[3:0] > 9. All tests use A before correction.
- R8: Decimal adjust adds the correction when N is 0 and subtracts it when N is 1, modulo 256. It keeps N, clears H, sets C when the correction includes 0x60, and sets Z when the new result is 0.
- R9: Complement (code 9) gives result = A ^ 0xFF, sets N and H, and keeps Z and C.
- R10: Set carry (code 10) keeps Z, clears N and H, and sets C. Complement carry (code 11) keeps Z, clears N and H, and inverts C. Both drive `result_o` equal to A.
- R11: Codes 12–15 do nothing. `result_o` equals A, `flags_o[7:4]` equals `flags_i[7:4]`, and the write-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Incoming flag byte (Z, N, H, C in bits 7..4) |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte, low nibble zero |
| acc_we_o | output | 1 | Accumulator write-enable |

## Verification
Two effects can land in the same evaluation in several places. The carrying operations can raise the half-carry and the full carry together from a single carry-in, for example 0x0F + 0xF0 with C set. Decimal adjust can apply both correction terms at once, for example 0x9A, where the low-nibble test and the combined high/low test agree. The bench sweeps every accumulator value against several operands and every combination of the incoming N, H and C bits. It then compares each result and flag bit against a model built from the requirement formulas, and adds hand-worked literal cases where both effects coincide.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW     = 8;
  localparam int NW     = 4;
  localparam int NSLICE = DW / NW;
  localparam int OPW    = 4;

  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_DAA = 4'd8,
    OP_CPL = 4'd9,
    OP_SCF = 4'd10,
    OP_CCF = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_nib_t;
endpackage

// File: rtl/acc_alu_slice.sv
module acc_alu_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
    s_o  = wide[W-1:0];
    co_o = wide[W];
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W  = DW,
  parameter int SW = NW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o
);
  localparam int NS = W / SW;

  logic [W-1:0] b_eff;
  logic [NS:0]  chain;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    chain[0] = sub_i ? ~cin_i : cin_i;
  end

  for (genvar g = 0; g < NS; g++) begin : g_slice
    acc_alu_slice #(.W(SW)) u_slice (
      .a_i (a_i[g*SW +: SW]),
      .b_i (b_eff[g*SW +: SW]),
      .ci_i(chain[g]),
      .s_o (sum_o[g*SW +: SW]),
      .co_o(chain[g+1])
    );
  end

  always_comb begin
    cy_o = sub_i ? ~chain[NS] : chain[NS];
    hc_o = sub_i ? ~chain[1]  : chain[1];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [OPW-1:0] op_i,
  output logic [W-1:0]   res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
  import acc_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a_i,
  input  logic         n_i,
  input  logic         h_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  localparam int HW = W / 2;
  localparam logic [HW-1:0] NINE  = HW'(9);
  localparam logic [HW-1:0] EIGHT = HW'(8);
  localparam logic [W-1:0]  LOFIX = W'(6);
  localparam logic [W-1:0]  HIFIX = W'(6) << HW;

  logic [HW-1:0] lo_dig;
  logic [HW-1:0] hi_dig;
  logic          lo_big;
  logic          need_lo;
  logic          need_hi;
  logic [W-1:0]  corr;

  always_comb begin
    lo_dig  = a_i[HW-1:0];
    hi_dig  = a_i[W-1:HW];
    lo_big  = lo_dig > NINE;
    need_lo = h_i || lo_big;
    need_hi = c_i || (hi_dig > NINE) || ((hi_dig > EIGHT) && lo_big);
    corr    = (need_lo ? LOFIX : '0) | (need_hi ? HIFIX : '0);
    res_o   = n_i ? (a_i - corr) : (a_i + corr);
    cy_o    = need_hi;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [3:0] op_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o,
  output logic       acc_we_o
);
  localparam int LOWBITS = DW - 4;

  flag_nib_t     fin;
  flag_nib_t     fout;
  logic          is_sub;
  logic          use_cin;
  logic [DW-1:0] as_sum;
  logic          as_cy;
  logic          as_hc;
  logic [DW-1:0] lg_res;
  logic [DW-1:0] da_res;
  logic          da_cy;

  always_comb begin
    fin     = flag_nib_t'(flags_i[DW-1:LOWBITS]);
    is_sub  = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP);
    use_cin = (op_i == OP_ADC) || (op_i == OP_SBC);
  end

  acc_alu_addsub #(.W(DW), .SW(NW)) u_addsub (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .sub_i(is_sub),
    .cin_i(use_cin & fin.c),
    .sum_o(as_sum),
    .cy_o (as_cy),
    .hc_o (as_hc)
  );

  acc_alu_logic #(.W(DW)) u_logic (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .op_i (op_i),
    .res_o(lg_res)
  );

  acc_alu_decadj #(.W(DW)) u_decadj (
    .a_i  (acc_i),
    .n_i  (fin.n),
    .h_i  (fin.h),
    .c_i  (fin.c),
    .res_o(da_res),
    .cy_o (da_cy)
  );

  always_comb begin
    result_o = acc_i;
    fout     = fin;
    acc_we_o = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        result_o = as_sum;
        fout     = '{z: (as_sum == '0), n: is_sub, h: as_hc, c: as_cy};
        acc_we_o = 1'b1;
      end
      OP_CMP: begin
        fout = '{z: (as_sum == '0), n: 1'b1, h: as_hc, c: as_cy};
      end
      OP_AND, OP_XOR, OP_OR: begin
        result_o = lg_res;
        fout     = '{z: (lg_res == '0), n: 1'b0, h: 1'b0, c: 1'b0};
        acc_we_o = 1'b1;
      end
      OP_DAA: begin
        result_o = da_res;
        fout     = '{z: (da_res == '0), n: fin.n, h: 1'b0, c: da_cy};
        acc_we_o = 1'b1;
      end
      OP_CPL: begin
        result_o = ~acc_i;
        fout     = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
        acc_we_o = 1'b1;
      end
      OP_SCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
      OP_CCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
      default: ;
    endcase
    flags_o = {fout, {LOWBITS{1'b0}}};
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [7:0] flags_i,
  input logic [3:0] op_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o,
  input logic       acc_we_o
);
  always_comb begin
    p_low_nibble_zero_r2: assert (flags_o[3:0] == 4'h0)
      else $error("R2 low nibble of flags not zero");
    if (op_i == OP_ADD) begin
      p_add_carry_wrap_r3: assert (flags_o[FC] == (result_o < acc_i) && !flags_o[FN])
        else $error("R3 add carry mismatch");
    end
    if (op_i == OP_SUB || op_i == OP_SBC) begin
      p_sub_sets_n_r4: assert (flags_o[FN] && acc_we_o)
        else $error("R4 subtract N/we");
    end
    if (op_i == OP_CMP) begin
      p_cmp_holds_acc_r5: assert (!acc_we_o && result_o == acc_i && flags_o[FN]
                                  && flags_o[FZ] == (acc_i == opnd_i))
        else $error("R5 compare behaviour");
    end
    if (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR) begin
      p_logic_only_z_r6: assert (flags_o[6:4] == 3'b000 && flags_o[FZ] == (result_o == 8'h00))
        else $error("R6 logic flags");
    end
    if (op_i == OP_DAA) begin
      p_daa_keeps_n_r8: assert (!flags_o[FH] && flags_o[FN] == flags_i[FN]
                                && flags_o[FZ] == (result_o == 8'h00))
        else $error("R8 decimal adjust flags");
    end
    if (op_i == OP_CPL) begin
      p_cpl_inverts_r9: assert ((result_o ^ acc_i) == 8'hFF && flags_o[FN] && flags_o[FH])
        else $error("R9 complement");
    end
    if (op_i == OP_SCF || op_i == OP_CCF) begin
      p_carry_ops_z_r10: assert (flags_o[FZ] == flags_i[FZ] && !acc_we_o
                                 && flags_o[FC] == ((op_i == OP_SCF) || !flags_i[FC]))
        else $error("R10 carry op");
    end
    if (op_i > OP_CCF) begin
      p_unused_inert_r11: assert (!acc_we_o && result_o == acc_i
                                  && flags_o[7:4] == flags_i[7:4])
        else $error("R11 unused code");
    end
    p_we_codes_r1: assert (acc_we_o == ((op_i <= OP_OR) || op_i == OP_DAA || op_i == OP_CPL))
      else $error("R1 write enable");
  end
endmodule

bind acc_alu acc_alu_chk u_chk (
  .acc_i   (acc_i),
  .opnd_i  (opnd_i),
  .flags_i (flags_i),
  .op_i    (op_i),
  .result_o(result_o),
  .flags_o (flags_o),
  .acc_we_o(acc_we_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] flags_i = 8'h00;
  logic [3:0] op_i = 4'd12;
  logic [7:0] result_o;
  logic [7:0] flags_o;
  logic       acc_we_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .op_i    (op_i),
    .result_o(result_o),
    .flags_o (flags_o),
    .acc_we_o(acc_we_o)
  );

  // Expected {we, result, flags} from the requirement formulas.
  function automatic logic [16:0] model(input int op, input int a, input int b, input int f);
    int  r, cin, full, lo, d;
    bit  we, z, n, h, c;
    we = 0; r = a; z = f[7]; n = f[6]; h = f[5]; c = f[4];
    case (op)
      0, 1: begin
        cin  = (op == 1) ? f[4] : 0;
        full = a + b + cin;
        r    = full % 256;
        c    = full >= 256;
        h    = ((a % 16) + (b % 16) + cin) >= 16;
        n    = 0; z = (r == 0); we = 1;
      end
      2, 3, 7: begin
        cin  = (op == 3) ? f[4] : 0;
        full = a - b - cin;
        c    = full < 0;
        h    = ((a % 16) - (b % 16) - cin) < 0;
        n    = 1; z = (((full + 512) % 256) == 0);
        if (op != 7) begin r = (full + 512) % 256; we = 1; end
      end
      4, 5, 6: begin
        r  = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        z  = (r == 0); n = 0; h = 0; c = 0; we = 1;
      end
      8: begin
        lo = a % 16; d = 0;
        if (f[5] || lo > 9) d = d + 6;
        if (f[4] || (a / 16) > 9 || ((a / 16) > 8 && lo > 9)) d = d + 96;
        r  = f[6] ? (a - d + 256) % 256 : (a + d) % 256;
        c  = d >= 96; h = 0; z = (r == 0); we = 1;
      end
      9:  begin r = 255 - a; n = 1; h = 1; we = 1; end
      10: begin n = 0; h = 0; c = 1; end
      11: begin n = 0; h = 0; c = !f[4]; end
      default: ;
    endcase
    model = {we, r[7:0], z, n, h, c, 4'h0};
  endfunction

  task automatic apply(input int op, input int a, input int b, input int f);
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f[7:0];
    #1;
  endtask

  task automatic check_model(input string tag, input int op, input int a, input int b, input int f);
    logic [16:0] exp;
    apply(op, a, b, f);
    exp = model(op, a, b, f);
    n_checks++;
    if ({acc_we_o, result_o, flags_o} !== exp) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: actual we=%b r=%02h f=%02h expected we=%b r=%02h f=%02h",
               tag, op, a, b, f, acc_we_o, result_o, flags_o, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic check_lit(input string tag, input int op, input int a, input int b, input int f,
                           input logic we, input logic [7:0] r, input logic [7:0] fl);
    apply(op, a, b, f);
    n_checks++;
    if ({acc_we_o, result_o, flags_o} !== {we, r, fl}) begin
      n_fails++;
      $display("FAIL %s literal: actual we=%b r=%02h f=%02h expected we=%b r=%02h f=%02h",
               tag, acc_we_o, result_o, flags_o, we, r, fl);
    end
  endtask

  // R11, R1: idle / unused codes, the initial state
  task automatic t_unused;
    check_lit("R11", 12, 8'h5A, 8'h00, 8'hF0, 1'b0, 8'h5A, 8'hF0);
    for (int op = 12; op < 16; op++) check_model("R11", op, 8'hC3, 8'h11, 8'hAF);
  endtask

  // R2: low nibble of flags in is ignored, low nibble out is zero
  task automatic t_flag_layout;
    for (int op = 0; op < 16; op++) check_model("R2", op, 8'h37, 8'h49, 8'h0F);
    check_lit("R2", 11, 8'h00, 8'h00, 8'h1F, 1'b0, 8'h00, 8'h00);
  endtask

  // R3: add / add-with-carry
  task automatic t_add;
    check_lit("R3", 0, 8'h0F, 8'h01, 8'h00, 1'b1, 8'h10, 8'h20);
    check_lit("R3", 1, 8'h0F, 8'hF0, 8'h10, 1'b1, 8'h00, 8'hB0);
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++) begin
        check_model("R3", 0, a, k * 85, 0);
        check_model("R3", 1, a, k * 77 + 1, 8'h10);
      end
  endtask

  // R4: subtract / subtract-with-borrow
  task automatic t_sub;
    check_lit("R4", 2, 8'h10, 8'h01, 8'h00, 1'b1, 8'h0F, 8'h60);
    check_lit("R4", 3, 8'h00, 8'h00, 8'h10, 1'b1, 8'hFF, 8'h70);
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++) begin
        check_model("R4", 2, a, k * 85, 8'h90);
        check_model("R4", 3, a, k * 77 + 3, 8'h10);
      end
  endtask

  // R5: compare leaves accumulator
  task automatic t_cmp;
    check_lit("R5", 7, 8'h42, 8'h42, 8'h00, 1'b0, 8'h42, 8'hC0);
    for (int a = 0; a < 256; a += 3) check_model("R5", 7, a, 8'h80, 8'h30);
  endtask

  // R6: logic operations
  task automatic t_logic;
    check_lit("R6", 4, 8'hF0, 8'h0F, 8'h70, 1'b1, 8'h00, 8'h80);
    check_lit("R6", 5, 8'hAA, 8'hA5, 8'hF0, 1'b1, 8'h0F, 8'h00);
    for (int op = 4; op < 7; op++)
      for (int a = 0; a < 256; a++) check_model("R6", op, a, 8'h3C, 8'hF0);
  endtask

  // R7, R8: decimal adjust over all N/H/C combinations
  task automatic t_daa;
    check_lit("R7", 8, 8'h9A, 8'h00, 8'h00, 1'b1, 8'h00, 8'h90);
    check_lit("R8", 8, 8'h0F, 8'h00, 8'h60, 1'b1, 8'h09, 8'h40);
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 8; fl++) check_model("R8", 8, a, 0, fl * 16);
  endtask

  // R9: complement
  task automatic t_cpl;
    check_lit("R9", 9, 8'h35, 8'h00, 8'h90, 1'b1, 8'hCA, 8'hF0);
    for (int a = 0; a < 256; a += 5) check_model("R9", 9, a, 0, 8'h00);
  endtask

  // R10: set / complement carry
  task automatic t_carry_ops;
    check_lit("R10", 10, 8'h11, 8'h00, 8'hE0, 1'b0, 8'h11, 8'h90);
    check_lit("R10", 11, 8'h22, 8'h00, 8'h70, 1'b0, 8'h22, 8'h00);
    for (int fl = 0; fl < 16; fl++) begin
      check_model("R10", 10, 8'h33, 0, fl * 16);
      check_model("R10", 11, 8'h33, 0, fl * 16);
    end
  endtask

  // R1: write-enable for every code
  task automatic t_we;
    for (int op = 0; op < 16; op++) check_model("R1", op, 8'h81, 8'h7E, 8'h50);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    t_unused();
    t_flag_layout();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_daa();
    t_cpl();
    t_carry_ops();
    t_we();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule